// File: doc/BRIEF.md
# Select-Driven Shared Adder Arithmetic Unit

This block is a purely combinational arithmetic stage built around a single ripple-carry adder. A 2-bit operation select drives a per-bit four-way multiplexer that decides what the adder's second operand is: the B operand as given, its bitwise inverse, a word of zeros, or a word of ones. The adder always forms A plus that operand plus the carry input, so the select code and the carry input together choose among plain addition, addition with carry, subtraction, subtraction with borrow, increment, decrement and pass-through of A.

The operand width is a parameter (default 4). The sum wraps modulo 2^WIDTH, and the carry out of the most significant stage is brought out as its own port. The block holds no state. Results settle from the inputs within the same time step, so surrounding logic can register them wherever it needs to.

Top module: `arith_unit_mux`

## Requirements
- R1: For every input combination, `{cout, res_d}` equals `op_a + Y + cin`, computed in WIDTH+1 bits, where Y is the operand picked by `op_sel`. `res_d` is that sum modulo 2^WIDTH, and `cout` is the carry out of the most significant stage.
- R2: `op_sel` = 2'b00 picks Y = `op_b`. With `cin` = 0 the result is A+B, and with `cin` = 1 it is A+B+1.
- R3: `op_sel` = 2'b01 picks Y = ~`op_b`.
  - With `cin` = 1 the result is A−B modulo 2^WIDTH, and `cout` = 1 exactly when A ≥ B unsigned.
  - With `cin` = 0 the result is A−B−1 modulo 2^WIDTH.
- R4: `op_sel` = 2'b10 picks Y = 0.
  - With `cin` = 0, `res_d` = A and `cout` = 0.
  - With `cin` = 1, `res_d` = A+1, and `cout` = 1 only when A is all ones.
- R5: `op_sel` = 2'b11 picks Y = all ones.
  - With `cin` = 0, `res_d` = A−1, and `cout` = 1 unless A = 0.
  - With `cin` = 1, `res_d` = A and `cout` = 1.
- R6: The block is combinational. A change on any input appears on `res_d` and `cout` in the same time step, with no clock involved.
- R7: The width is set by the parameter WIDTH (default 4). The same rules hold at other widths, including at the signed boundary operands 0, 1, 2^(WIDTH-1)−1, 2^(WIDTH-1) and all ones.
- R8: With `op_sel` = 2'b10 or 2'b11, the value of `op_b` has no effect on `res_d` or `cout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend, always fed straight to the adder |
| op_b | input | WIDTH | Source for the second addend when op_sel picks it or its inverse |
| op_sel | input | 2 | Operand select: 00 B, 01 ~B, 10 zeros, 11 ones |
| cin | input | 1 | Carry into the least significant stage |
| res_d | output | WIDTH | Sum modulo 2^WIDTH |
| cout | output | 1 | Carry out of the most significant stage |

## Verification
The only internal state is combinational: the selected operand and the carry chain. A wrong mux leg or a broken carry link shows at the ports in the same time step, as a wrong `res_d` or `cout` for some operand and select pair.

Carry faults show up only for particular operand values. Sweeping every A, B, select and carry-in at the default width therefore exposes every single-stage fault. A wider instance is also driven with the signed boundary values and random operands.

// File: rtl/mux_arith_pkg.sv
package mux_arith_pkg;

    // Choice of second addend; codes are fixed by the operation table.
    typedef enum logic [1:0] {
        SEL_PASS_B = 2'b00,
        SEL_INV_B  = 2'b01,
        SEL_ZERO   = 2'b10,
        SEL_ONES   = 2'b11
    } y_sel_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_out_t;

    // One full-adder cell.
    function automatic fa_out_t full_add(input logic x, input logic y, input logic ci);
        fa_out_t r;
        r.sum   = x ^ y ^ ci;
        r.carry = (x & y) | (x & ci) | (y & ci);
        return r;
    endfunction

    // One bit of the four-way operand multiplexer.
    function automatic logic mux4_bit(input y_sel_e s, input logic b);
        logic r;
        case (s)
            SEL_PASS_B: r = b;
            SEL_INV_B:  r = ~b;
            SEL_ZERO:   r = 1'b0;
            default:    r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/operand_select.sv
module operand_select
    import mux_arith_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  y_sel_e           sel,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] y_out
);

    // One multiplexer per bit position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit_mux
        always_comb y_out[i] = mux4_bit(sel, b_in[i]);
    end

    always_comb begin
        if (!$isunknown(sel) && !$isunknown(b_in)) begin
            if (sel == SEL_ZERO)
                p_zero_operand_r4: assert (y_out == '0);
            if (sel == SEL_ONES)
                p_ones_operand_r5: assert (&y_out);
            if (sel == SEL_INV_B)
                p_inverted_operand_r3: assert ((y_out ^ b_in) == '1);
            if (sel == SEL_PASS_B)
                p_passed_operand_r2: assert ((y_out ^ b_in) == '0);
        end
    end

endmodule

// File: rtl/ripple_chain.sv
module ripple_chain
    import mux_arith_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] s_out,
    output logic             c_out
);

    localparam int SUM_W = WIDTH + 1;

    // Each stage's carry feeds the next; the last one leaves as c_out.
    always_comb begin
        fa_out_t stage;
        logic    carry;
        carry = c_in;
        for (int i = 0; i < WIDTH; i++) begin
            stage    = full_add(x_in[i], y_in[i], carry);
            s_out[i] = stage.sum;
            carry    = stage.carry;
        end
        c_out = carry;
    end

    always_comb begin
        if (!$isunknown({x_in, y_in, c_in}))
            p_chain_sum_r1: assert ({c_out, s_out} ==
                SUM_W'({1'b0, x_in}) + SUM_W'({1'b0, y_in}) + SUM_W'(c_in));
    end

endmodule

// File: rtl/arith_unit_mux.sv
module arith_unit_mux
    import mux_arith_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [1:0]       op_sel,
    input  logic             cin,
    output logic [WIDTH-1:0] res_d,
    output logic             cout
);

    localparam int SUM_W = WIDTH + 1;

    y_sel_e           sel_e;
    logic [WIDTH-1:0] y_word;

    assign sel_e = y_sel_e'(op_sel);

    operand_select #(.WIDTH(WIDTH)) u_opsel (
        .sel   (sel_e),
        .b_in  (op_b),
        .y_out (y_word)
    );

    ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .x_in  (op_a),
        .y_in  (y_word),
        .c_in  (cin),
        .s_out (res_d),
        .c_out (cout)
    );

    // Port-level checks of the operation table.
    always_comb begin
        if (!$isunknown({op_a, op_b, op_sel, cin})) begin
            if (op_sel == 2'b10 && !cin)
                p_transfer_zero_r4: assert (res_d == op_a && !cout);
            if (op_sel == 2'b11 && cin)
                p_transfer_ones_r5: assert (res_d == op_a && cout);
            if (op_sel == 2'b01 && cin)
                p_subtract_r3: assert (res_d == WIDTH'(op_a - op_b) && cout == (op_a >= op_b));
            if (op_sel == 2'b00)
                p_add_r2: assert ({cout, res_d} ==
                    SUM_W'({1'b0, op_a}) + SUM_W'({1'b0, op_b}) + SUM_W'(cin));
        end
    end

endmodule

// File: tb/test_arith_unit_mux.sv
module test_arith_unit_mux;

    localparam int NW = 4;
    localparam int WW = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [NW-1:0] a4, b4, d4;
    logic [1:0]    s4;
    logic          c4, co4;
    logic [WW-1:0] a8, b8, d8;
    logic [1:0]    s8;
    logic          c8, co8;

    arith_unit_mux #(.WIDTH(NW)) i_arith_unit_mux (
        .op_a(a4), .op_b(b4), .op_sel(s4), .cin(c4), .res_d(d4), .cout(co4)
    );

    arith_unit_mux #(.WIDTH(WW)) i_arith_unit_mux_wide (
        .op_a(a8), .op_b(b8), .op_sel(s8), .cin(c8), .res_d(d8), .cout(co8)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Reference: {cout,d} = a + y + cin, y picked per select code.
    function automatic int ref_sum(input int w, input int a, input int b, input int s, input int c);
        int mask = (1 << w) - 1;
        int y;
        case (s)
            0: y = b;
            1: y = (~b) & mask;
            2: y = 0;
            default: y = mask;
        endcase
        return a + y + c;
    endfunction

    function automatic string tag(input int s);
        case (s)
            0: return "R2 add";
            1: return "R3 sub";
            2: return "R4 zero/inc";
            default: return "R5 dec/ones";
        endcase
    endfunction

    initial begin
        a4 = '0; b4 = '0; s4 = '0; c4 = 1'b0;
        a8 = '0; b8 = '0; s8 = '0; c8 = 1'b0;
        @(negedge clk); #2;
        // Idle state with all-zero inputs.
        check("R2 idle zero", {co4, d4}, 0);

        // R1: exhaustive sweep at the default width.
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 2; c++)
                for (int a = 0; a < 16; a++)
                    for (int b = 0; b < 16; b++) begin
                        @(negedge clk);
                        a4 = NW'(a); b4 = NW'(b); s4 = 2'(s); c4 = c[0];
                        #2;
                        check({"R1 ", tag(s)}, {co4, d4}, ref_sum(NW, a, b, s, c));
                    end

        // R6: result appears in the same time step, no clock edge between.
        @(posedge clk); #1;
        a4 = 4'h9; b4 = 4'h3; s4 = 2'b01; c4 = 1'b1;
        #1;
        check("R6 same-step", {co4, d4}, {1'b1, 4'h6});
        a4 = 4'h2; #1;
        check("R6 same-step", {co4, d4}, {1'b0, 4'hF});

        // R8: op_b ignored for select 10 and 11.
        for (int s = 2; s < 4; s++)
            for (int c = 0; c < 2; c++) begin
                @(negedge clk);
                a4 = 4'h5; b4 = 4'h0; s4 = 2'(s); c4 = c[0];
                #2;
                check("R8 b ignored (b=0)", {co4, d4}, ref_sum(NW, 5, 0, s, c));
                b4 = 4'hF; #2;
                check("R8 b ignored (b=F)", {co4, d4}, ref_sum(NW, 5, 0, s, c));
                b4 = 4'hA; #2;
                check("R8 b ignored (b=A)", {co4, d4}, ref_sum(NW, 5, 0, s, c));
            end

        // R7: wider instance, boundary operands.
        begin
            int edges [6] = '{0, 1, 8'h7F, 8'h80, 8'hFE, 8'hFF};
            for (int s = 0; s < 4; s++)
                for (int c = 0; c < 2; c++)
                    for (int i = 0; i < 6; i++)
                        for (int j = 0; j < 6; j++) begin
                            @(negedge clk);
                            a8 = WW'(edges[i]); b8 = WW'(edges[j]); s8 = 2'(s); c8 = c[0];
                            #2;
                            check({"R7 edge ", tag(s)}, {co8, d8},
                                  ref_sum(WW, edges[i], edges[j], s, c));
                        end
        end

        // R7: wider instance, random operands.
        for (int k = 0; k < 200; k++) begin
            int ra, rb, rs, rc;
            ra = int'($urandom_range(255, 0));
            rb = int'($urandom_range(255, 0));
            rs = int'($urandom_range(3, 0));
            rc = int'($urandom_range(1, 0));
            @(negedge clk);
            a8 = WW'(ra); b8 = WW'(rb); s8 = 2'(rs); c8 = rc[0];
            #2;
            check({"R7 random ", tag(rs)}, {co8, d8}, ref_sum(WW, ra, rb, rs, rc));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule